// File: doc/BRIEF.md
# High-Order Virtual Concatenation Overhead Decoder

This block sits on the receive side of one member path of a virtually concatenated group. Once per frame it takes the single path-overhead byte that carries the concatenation control information. From the 4-bit frame count in that byte it follows a 16-frame multiframe. It rebuilds the 8-bit multiframe count, which arrives as two nibbles. It joins the two counts into a 12-bit position that wraps every 4096 frames, and this position is what a later deskew stage uses to align the members. The block also recovers the member's 8-bit sequence number and reports lock, loss and counter-consistency status.

The overhead bytes enter as a stream with a valid/ready handshake. The decoder never applies back-pressure: `ovh_ready` is high at all times, and a byte is consumed on every clock cycle in which `ovh_valid` is high. Idle cycles are allowed anywhere and have no effect on the block. All status outputs are plain registered levels, and each one updates on the clock edge that consumes the byte that changes it.

Top module: `ho_vcat_oh_decoder`

## Requirements
- R1: `ovh_ready` is always 1. A byte is consumed on each rising clock edge with `ovh_valid` high. Bits [3:0] of the byte hold the frame count and bits [7:4] hold the field nibble.
- R2: A byte "steps" when a byte has already been consumed since reset and its frame count equals the previous byte's frame count plus 1 (mod 16). The first byte after reset neither steps nor fails. `mf_lock` rises on the third consecutive stepping byte.
- R3: `mf_loss` is set and `mf_lock` is cleared on the third consecutive non-stepping byte. Fewer than three failures leave `mf_lock` unchanged. `mf_loss` clears when lock is declared again, and the two are never high together.
- R4: The multiframe count is rebuilt from its high nibble, taken at frame count 0, and its low nibble, taken at frame count 1. The rebuild happens only when the frame-1 byte steps. `mfi[3:0]` follows the frame count of every consumed byte. `mfi[11:4]` loads the rebuilt value at each rebuild, and it increments by one on each stepping byte with frame count 0.
- R5: At each rebuild, `mfi_err` becomes 1 if the rebuilt value differs from the previous rebuilt value plus 1 (mod 256), and 0 otherwise. With no previous value it becomes 0. It holds between rebuilds.
- R6: A sequence candidate is rebuilt from the high nibble at frame count 14 and the low nibble at frame count 15, provided the frame-15 byte steps. `seq_num` and `seq_valid` update only when a candidate equals the candidate from the previous rebuild. Once set, `seq_valid` stays 1.
- R7: After reset: `mf_lock`=0, `mf_loss`=0, `mfi`=0, `mfi_err`=0, `seq_num`=0 and `seq_valid`=0.
- R8: Declaring loss discards the multiframe-count history, so the first rebuild after a loss gives `mfi_err`=0 whatever value it carries.
- R9: A cycle with `ovh_valid` low changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovh_valid | input | 1 | Overhead byte present |
| ovh_ready | output | 1 | Always 1; no back-pressure |
| ovh_byte | input | 8 | Overhead byte: [3:0] frame count, [7:4] field nibble |
| mfi | output | 12 | Combined multiframe position {8-bit count, frame count} |
| mfi_err | output | 1 | Last rebuilt multiframe count was not previous plus one |
| seq_num | output | 8 | Confirmed sequence number |
| seq_valid | output | 1 | `seq_num` has been confirmed at least once |
| mf_lock | output | 1 | Multiframe lock |
| mf_loss | output | 1 | Loss of multiframe |

## Verification
The assertions check the cycle-level invariants on every cycle. They cover: lock and loss never both high; lock rising only on a stepping byte; a rebuild never firing on two cycles in a row; the error flag rising only at a rebuild; the sequence number changing only on a candidate, with its valid flag sticky; and idle cycles leaving the status untouched. Only the bench scenarios can show that the values are right. That covers the 12-bit position tracked across a wrap of the 8-bit count, the lock and loss points after exactly three good or bad frames, the error flag raised by a jump and cleared by the next consistent multiframe, and history cleared after a loss. It also covers a sequence number that is published only after two matching multiframes and never for a one-multiframe glitch.

// File: rtl/ho_vcat_pkg.sv
package ho_vcat_pkg;
  localparam int FI_W    = 4;
  localparam int NIB_W   = 4;
  localparam int FIELD_W = 2 * NIB_W;
  localparam int POS_W   = FIELD_W + FI_W;
  localparam int BYTE_W  = NIB_W + FI_W;

  typedef logic [FI_W-1:0]    fi_t;
  typedef logic [NIB_W-1:0]   nib_t;
  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [POS_W-1:0]   pos_t;
endpackage

// File: rtl/ho_vcat_fi_tracker.sv
module ho_vcat_fi_tracker
  import ho_vcat_pkg::*;
#(
  parameter int LOCK_FRAMES = 3,
  parameter int LOSS_FRAMES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  fi_t  fi,
  output logic step_ok,
  output logic loss_evt,
  output logic locked,
  output logic lost
);
  localparam int MAXC = (LOCK_FRAMES > LOSS_FRAMES) ? LOCK_FRAMES : LOSS_FRAMES;
  localparam int CW   = $clog2(MAXC + 1);

  fi_t           prev_fi;
  logic          have_prev;
  logic [CW-1:0] good_cnt;
  logic [CW-1:0] bad_cnt;
  logic          step_bad;
  logic          lock_evt;

  assign step_ok  = in_valid && have_prev && (fi == prev_fi + fi_t'(1));
  assign step_bad = in_valid && have_prev && (fi != prev_fi + fi_t'(1));
  assign lock_evt = step_ok  && (good_cnt >= CW'(LOCK_FRAMES - 1));
  assign loss_evt = step_bad && (bad_cnt  >= CW'(LOSS_FRAMES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_fi   <= '0;
      have_prev <= 1'b0;
      good_cnt  <= '0;
      bad_cnt   <= '0;
      locked    <= 1'b0;
      lost      <= 1'b0;
    end else if (in_valid) begin
      prev_fi   <= fi;
      have_prev <= 1'b1;
      if (step_ok) begin
        bad_cnt <= '0;
        if (good_cnt < CW'(LOCK_FRAMES)) good_cnt <= good_cnt + 1'b1;
        if (lock_evt) begin
          locked <= 1'b1;
          lost   <= 1'b0;
        end
      end else if (step_bad) begin
        good_cnt <= '0;
        if (bad_cnt < CW'(LOSS_FRAMES)) bad_cnt <= bad_cnt + 1'b1;
        if (loss_evt) begin
          locked <= 1'b0;
          lost   <= 1'b1;
        end
      end
    end
  end

  // R3
  lock_loss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && lost));

  // R2
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(step_ok));

  // R9
  fi_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(locked) && $stable(lost)));
endmodule

// File: rtl/ho_vcat_nib_asm.sv
module ho_vcat_nib_asm
  import ho_vcat_pkg::*;
#(
  parameter int HI_POS = 0,
  parameter int LO_POS = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  input  logic   step_ok,
  input  fi_t    fi,
  input  nib_t   nib,
  output logic   done,
  output field_t value
);
  nib_t hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                hi_q <= '0;
    else if (in_valid && fi == fi_t'(HI_POS))  hi_q <= nib;
  end

  assign done  = step_ok && (fi == fi_t'(LO_POS));
  assign value = {hi_q, nib};

  // R4
  asm_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  asm_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_valid);
endmodule

// File: rtl/ho_vcat_mfi_track.sv
module ho_vcat_mfi_track
  import ho_vcat_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  input  logic   step_ok,
  input  fi_t    fi,
  input  logic   asm_done,
  input  field_t asm_value,
  input  logic   clear_hist,
  output pos_t   mfi,
  output logic   mfi_err
);
  field_t mf_cnt;
  fi_t    fi_q;
  field_t last_rx;
  logic   have_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mf_cnt  <= '0;
      fi_q    <= '0;
      last_rx <= '0;
      have_rx <= 1'b0;
      mfi_err <= 1'b0;
    end else begin
      if (in_valid) fi_q <= fi;
      if (asm_done) begin
        mf_cnt  <= asm_value;
        last_rx <= asm_value;
        have_rx <= 1'b1;
        mfi_err <= have_rx && (asm_value != last_rx + field_t'(1));
      end else if (step_ok && fi == '0) begin
        mf_cnt <= mf_cnt + field_t'(1);
      end
      if (clear_hist) have_rx <= 1'b0;
    end
  end

  assign mfi = {mf_cnt, fi_q};

  // R5
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mfi_err) |-> $past(asm_done));

  // R9
  mfi_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(mfi) && $stable(mfi_err)));
endmodule

// File: rtl/ho_vcat_seq_filter.sv
module ho_vcat_seq_filter
  import ho_vcat_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cand_done,
  input  field_t cand,
  output field_t seq_num,
  output logic   seq_valid
);
  field_t last_cand;
  logic   have_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_cand <= '0;
      have_last <= 1'b0;
      seq_num   <= '0;
      seq_valid <= 1'b0;
    end else if (cand_done) begin
      last_cand <= cand;
      have_last <= 1'b1;
      if (have_last && cand == last_cand) begin
        seq_num   <= cand;
        seq_valid <= 1'b1;
      end
    end
  end

  // R6
  seq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_valid |=> seq_valid);

  // R6
  seq_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seq_num) |-> $past(cand_done));
endmodule

// File: rtl/ho_vcat_oh_decoder.sv
module ho_vcat_oh_decoder
  import ho_vcat_pkg::*;
#(
  parameter int LOCK_FRAMES = 3,
  parameter int LOSS_FRAMES = 3,
  parameter int MF_HI_POS   = 0,
  parameter int SQ_HI_POS   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovh_valid,
  output logic              ovh_ready,
  input  logic [BYTE_W-1:0] ovh_byte,
  output logic [POS_W-1:0]  mfi,
  output logic              mfi_err,
  output logic [FIELD_W-1:0] seq_num,
  output logic              seq_valid,
  output logic              mf_lock,
  output logic              mf_loss
);
  localparam int MF_LO_POS = MF_HI_POS + 1;
  localparam int SQ_LO_POS = SQ_HI_POS + 1;

  fi_t    fi;
  nib_t   nib;
  logic   step_ok;
  logic   loss_evt;
  logic   mf_done;
  field_t mf_value;
  logic   sq_done;
  field_t sq_value;

  assign ovh_ready = 1'b1;
  assign fi        = ovh_byte[FI_W-1:0];
  assign nib       = ovh_byte[BYTE_W-1:FI_W];

  ho_vcat_fi_tracker #(
    .LOCK_FRAMES (LOCK_FRAMES),
    .LOSS_FRAMES (LOSS_FRAMES)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (ovh_valid),
    .fi       (fi),
    .step_ok  (step_ok),
    .loss_evt (loss_evt),
    .locked   (mf_lock),
    .lost     (mf_loss)
  );

  ho_vcat_nib_asm #(.HI_POS(MF_HI_POS), .LO_POS(MF_LO_POS)) u_mf_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (ovh_valid),
    .step_ok  (step_ok),
    .fi       (fi),
    .nib      (nib),
    .done     (mf_done),
    .value    (mf_value)
  );

  ho_vcat_nib_asm #(.HI_POS(SQ_HI_POS), .LO_POS(SQ_LO_POS)) u_sq_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (ovh_valid),
    .step_ok  (step_ok),
    .fi       (fi),
    .nib      (nib),
    .done     (sq_done),
    .value    (sq_value)
  );

  ho_vcat_mfi_track u_mfi (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (ovh_valid),
    .step_ok    (step_ok),
    .fi         (fi),
    .asm_done   (mf_done),
    .asm_value  (mf_value),
    .clear_hist (loss_evt),
    .mfi        (mfi),
    .mfi_err    (mfi_err)
  );

  ho_vcat_seq_filter u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand_done (sq_done),
    .cand      (sq_value),
    .seq_num   (seq_num),
    .seq_valid (seq_valid)
  );

  // R4
  rebuild_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mf_done && sq_done));
endmodule

// File: tb/ho_vcat_oh_decoder_test.sv
`timescale 1ns/1ps
module ho_vcat_oh_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ovh_valid = 1'b0;
  logic        ovh_ready;
  logic [7:0]  ovh_byte = 8'h00;
  logic [11:0] mfi;
  logic        mfi_err;
  logic [7:0]  seq_num;
  logic        seq_valid;
  logic        mf_lock;
  logic        mf_loss;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ho_vcat_oh_decoder uut (
    .clk(clk), .rst_n(rst_n), .ovh_valid(ovh_valid), .ovh_ready(ovh_ready),
    .ovh_byte(ovh_byte), .mfi(mfi), .mfi_err(mfi_err), .seq_num(seq_num),
    .seq_valid(seq_valid), .mf_lock(mf_lock), .mf_loss(mf_loss)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] fbyte(input logic [11:0] n, input logic [7:0] s);
    logic [3:0] f;
    logic [7:0] m;
    logic [3:0] top;
    f = n[3:0];
    m = n[11:4];
    case (f)
      4'd0:    top = m[7:4];
      4'd1:    top = m[3:0];
      4'd14:   top = s[7:4];
      4'd15:   top = s[3:0];
      default: top = 4'h0;
    endcase
    return {top, f};
  endfunction

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    ovh_valid = 1'b1;
    ovh_byte  = b;
    @(posedge clk);
    #1 ovh_valid = 1'b0;
  endtask

  task automatic idle_check();
    logic [11:0] m0;
    logic [7:0]  s0;
    logic [4:0]  f0;
    m0 = mfi; s0 = seq_num; f0 = {mfi_err, seq_valid, mf_lock, mf_loss, ovh_ready};
    @(negedge clk);
    ovh_valid = 1'b0;
    ovh_byte  = 8'hFF;
    @(posedge clk);
    #1;
    chk(mfi == m0 && seq_num == s0 && {mfi_err, seq_valid, mf_lock, mf_loss, ovh_ready} == f0,
        "R9 idle", {mfi, seq_num, 7'd0, mfi_err, seq_valid, mf_lock, mf_loss, ovh_ready},
        {m0, s0, 7'd0, f0});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ovh_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(mf_lock == 0 && mf_loss == 0 && mfi == 0 && mfi_err == 0 && seq_num == 0 && seq_valid == 0,
        "R7 reset", {mfi, seq_num, mfi_err, seq_valid, mf_lock, mf_loss}, 32'h0);
    chk(ovh_ready == 1'b1, "R1 ready", ovh_ready, 1);
  endtask

  // Sweep of a clean stream: returns the next position to send.
  task automatic run_clean(input logic [7:0] m0, input logic [7:0] s, input int nmf,
                           output logic [11:0] next_n);
    logic [11:0] n;
    do_reset();
    for (int j = 0; j < nmf * 16; j++) begin
      n = {m0, 4'h0} + 12'(j);
      send(fbyte(n, s));
      if (j == 0) chk(mfi == {8'h00, n[3:0]}, "R4 first byte", mfi, {8'h00, n[3:0]});
      else        chk(mfi == n, "R4 position", mfi, n);
      if (j == 2) chk(mf_lock == 0, "R2 no lock yet", mf_lock, 0);
      if (j >= 3) chk(mf_lock == 1 && mf_loss == 0, "R2 locked", {mf_lock, mf_loss}, 2'b10);
      chk(mfi_err == 0, "R5 clean", mfi_err, 0);
      chk(seq_valid == (j >= 31), "R6 valid", seq_valid, (j >= 31));
      chk(seq_num == ((j >= 31) ? s : 8'h00), "R6 value", seq_num, (j >= 31) ? s : 8'h00);
      chk(ovh_ready == 1'b1, "R1 ready", ovh_ready, 1);
      if (j % 7 == 3) idle_check();
    end
    next_n = {m0, 4'h0} + 12'(nmf * 16);
  endtask

  task automatic send_mf(input logic [11:0] base, input logic [7:0] s);
    for (int k = 0; k < 16; k++) send(fbyte(base + 12'(k), s));
  endtask

  initial begin
    logic [11:0] nn;
    logic [7:0]  p;
    run_clean(8'hF0, 8'hA5, 40, nn);
    run_clean(8'h00, 8'h00, 20, nn);
    run_clean(8'h7E, 8'hFF, 40, nn);

    // R5: jump of the 8-bit count by +5 instead of +1
    p  = nn[11:4] - 8'd1;
    nn = nn + 12'd64;
    send(fbyte(nn, 8'hFF));
    chk(mfi == {p + 8'd1, 4'h0}, "R4 predicted increment", mfi, {p + 8'd1, 4'h0});
    send(fbyte(nn + 12'd1, 8'hFF));
    chk(mfi == nn + 12'd1, "R4 loads rebuilt", mfi, nn + 12'd1);
    chk(mfi_err == 1, "R5 jump flagged", mfi_err, 1);
    for (int k = 2; k < 16; k++) send(fbyte(nn + 12'(k), 8'hFF));
    chk(mfi_err == 1, "R5 flag held", mfi_err, 1);
    nn = nn + 12'd16;
    send(fbyte(nn, 8'hFF));
    send(fbyte(nn + 12'd1, 8'hFF));
    chk(mfi_err == 0, "R5 cleared by consistent", mfi_err, 0);
    for (int k = 2; k < 16; k++) send(fbyte(nn + 12'(k), 8'hFF));
    nn = nn + 12'd16;

    // R6: one-multiframe glitch is not published, two matches are
    send_mf(nn, 8'h3C); nn = nn + 12'd16;
    chk(seq_num == 8'hFF, "R6 single new value held off", seq_num, 8'hFF);
    send_mf(nn, 8'hFF); nn = nn + 12'd16;
    chk(seq_num == 8'hFF, "R6 glitch ignored", seq_num, 8'hFF);
    send_mf(nn, 8'h3C); nn = nn + 12'd16;
    chk(seq_num == 8'hFF, "R6 first of pair", seq_num, 8'hFF);
    send_mf(nn, 8'h3C); nn = nn + 12'd16;
    chk(seq_num == 8'h3C && seq_valid, "R6 pair published", seq_num, 8'h3C);

    // R3: three failing frames declare loss
    send(8'h05);
    chk(mf_lock == 1 && mf_loss == 0, "R3 one failure", {mf_lock, mf_loss}, 2'b10);
    send(8'h05);
    chk(mf_lock == 1 && mf_loss == 0, "R3 two failures", {mf_lock, mf_loss}, 2'b10);
    send(8'h05);
    chk(mf_lock == 0 && mf_loss == 1, "R3 loss declared", {mf_lock, mf_loss}, 2'b01);
    idle_check();

    // R8: relock on an unrelated count, no error on first rebuild
    nn = 12'h330;
    send(fbyte(nn, 8'h3C));
    chk(mf_loss == 1, "R3 loss held", mf_loss, 1);
    send(fbyte(nn + 12'd1, 8'h3C));
    chk(mfi == 12'h331, "R4 rebuild after loss", mfi, 12'h331);
    chk(mfi_err == 0, "R8 history cleared", mfi_err, 0);
    send(fbyte(nn + 12'd2, 8'h3C));
    chk(mf_lock == 0 && mf_loss == 1, "R2 two steps", {mf_lock, mf_loss}, 2'b01);
    send(fbyte(nn + 12'd3, 8'h3C));
    chk(mf_lock == 1 && mf_loss == 0, "R3 relock clears loss", {mf_lock, mf_loss}, 2'b10);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule